// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drives the transmit side of an Ethernet MAC's DMA. Software builds a ring of 16-byte transmit descriptors in memory, points the block at the first one and writes a poll-demand register. The block then reads descriptors in ring order. For each descriptor the controller owns, it presents the buffer address, byte count and segment flags to the transmit data path, waits for that frame to complete, and writes the descriptor's status word back with the ownership bit cleared and the abort causes filled in. It then pulses a transmit-done status pin and moves on to the next descriptor.

The walk stops at the first descriptor that software still owns. A later poll demand restarts the walk from where it stopped. A descriptor whose end-of-ring flag is set sends the walk back to the ring base. A transmit-enable pin gates all fetching. The command interface to the data path is valid/ready: the block raises `cmd_valid` with stable fields and holds them until `cmd_ready` is high at a clock edge. Only one frame is outstanding at a time. The memory port is a single-outstanding request/ready master, and read data returns on `mem_rvalid` at least one cycle after the request is accepted.

Top module: `txr_walker`

## Requirements
- R1: After reset, `mem_req`, `cmd_valid` and `tx_done` are low, and the ring position equals the base address, which is 0.
- R2: A register write to offset 24 (any data) latches a poll demand. The demand starts a scan from the current ring position as soon as `tx_en` is high and the block is idle. A demand made while `tx_en` is low is kept until `tx_en` rises.
- R3: A descriptor whose word 0 (byte offset 0) has bit 31 clear ends the scan. The block issues no command for it and writes nothing to memory.
- R4: For an owned descriptor, the command carries `cmd_addr` = word 2 (byte offset 8), `cmd_len` = word 1 (byte offset 4) bits 10:0, `cmd_first` = word 1 bit 28 and `cmd_last` = word 1 bit 27.
- R5: Once `cmd_valid` is high, it and all command fields stay unchanged until a cycle in which `cmd_ready` is high.
- R6: Only one frame is in flight. After `done_valid`, word 0 of that descriptor is written as bit 0 = `done_late`, bit 1 = `done_excess`, and all other bits 0, so bit 31 is cleared. No further command is issued before that write.
- R7: `tx_done` is high for exactly one cycle per completed frame, in the cycle after the status write is accepted.
- R8: After a descriptor whose word 1 bit 31 is set, the next descriptor is read at the ring base. Otherwise the next descriptor is 16 bytes further on.
- R9: A register write to offset 32 loads the ring base from the write data, with bits 3:0 forced to 0, and sets the ring position to that base.
- R10: Clearing `tx_en` lets the frame in progress finish, including its status write, and then stops the walk. While the block is idle with `tx_en` low, it starts no memory request.
- R11: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable until a cycle with `mem_ready` high. Descriptor words are read back correctly under any pattern of `mem_ready` stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable; gates all fetching |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| cmd_valid | output | 1 | Frame command valid |
| cmd_ready | input | 1 | Data path accepts the command |
| cmd_addr | output | AW | Frame buffer address |
| cmd_len | output | 11 | Frame length in bytes |
| cmd_first | output | 1 | First-segment flag |
| cmd_last | output | 1 | Last-segment flag |
| done_valid | input | 1 | Data path finished the frame in flight |
| done_late | input | 1 | Frame aborted by a late collision |
| done_excess | input | 1 | Frame aborted by excessive collisions |
| tx_done | output | 1 | One-cycle transmit-done status pulse |

## Verification
The walk is tried with five descriptor layouts:
- a single owned descriptor followed by a software-owned one;
- a two-entry ring closed by the end flag and then re-polled;
- a poll with nothing owned;
- two owned entries with `tx_en` dropped in between;
- a reload of the base register onto a ring whose position had moved on.

Together these separate a walk that stops on ownership from one that runs on, a wrap taken from the end flag from plain address increment, and a position kept across polls from one reset by a base load. Distinct abort flags on consecutive frames show that each status write reaches its own descriptor with the right bits. A run with a stalled memory port and a held-off data path shows whether command fields and descriptor reads survive back-pressure.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int WORD_W     = 32;
  localparam int LEN_W      = 11;
  localparam int OWN_BIT    = 31;
  localparam int RINGEND_BIT = 31;
  localparam int FIRST_BIT  = 28;
  localparam int LAST_BIT   = 27;
  localparam int DESC_BYTES = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RREQ,
    ST_RWAIT,
    ST_CMD,
    ST_BUSY,
    ST_WB
  } walk_state_t;
endpackage

// File: rtl/txr_regs.sv
module txr_regs #(
  parameter int AW       = 32,
  parameter int RAW      = 8,
  parameter int POLL_OFS = 24,
  parameter int BASE_OFS = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic [RAW-1:0]             reg_addr,
  input  logic [txr_pkg::WORD_W-1:0] reg_wdata,
  input  logic                       poll_take,
  output logic                       poll_pend,
  output logic [AW-1:0]              base_q,
  output logic                       base_load
);
  localparam logic [RAW-1:0] POLL_A = RAW'(POLL_OFS);
  localparam logic [RAW-1:0] BASE_A = RAW'(BASE_OFS);

  logic poll_hit, base_hit;
  assign poll_hit = reg_wr && (reg_addr == POLL_A);
  assign base_hit = reg_wr && (reg_addr == BASE_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_pend <= 1'b0;
      base_q    <= '0;
      base_load <= 1'b0;
    end else begin
      if (poll_hit)       poll_pend <= 1'b1;
      else if (poll_take) poll_pend <= 1'b0;
      base_load <= base_hit;
      if (base_hit) base_q <= {reg_wdata[AW-1:4], 4'b0000};
    end
  end
endmodule

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_q,
  input  logic          base_load,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] STEP = AW'(txr_pkg::DESC_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr <= '0;
    else if (base_load) ptr <= base_q;
    else if (adv)       ptr <= wrap ? base_q : ptr + STEP;
  end

  // R9
  ptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr[3:0] == 4'b0000);
endmodule

// File: rtl/txr_engine.sv
module txr_engine #(
  parameter int AW = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tx_en,
  input  logic                        poll_pend,
  output logic                        poll_take,
  input  logic [AW-1:0]               ptr,
  output logic                        adv,
  output logic                        wrap,
  output logic                        mem_req,
  output logic                        mem_we,
  output logic [AW-1:0]               mem_addr,
  output logic [txr_pkg::WORD_W-1:0]  mem_wdata,
  input  logic                        mem_ready,
  input  logic                        mem_rvalid,
  input  logic [txr_pkg::WORD_W-1:0]  mem_rdata,
  output logic                        cmd_valid,
  input  logic                        cmd_ready,
  output logic [AW-1:0]               cmd_addr,
  output logic [txr_pkg::LEN_W-1:0]   cmd_len,
  output logic                        cmd_first,
  output logic                        cmd_last,
  input  logic                        done_valid,
  input  logic                        done_late,
  input  logic                        done_excess,
  output logic                        tx_done
);
  import txr_pkg::*;

  walk_state_t st;
  logic [1:0]  widx;
  logic        end_q, late_q, exc_q;

  assign poll_take = (st == ST_IDLE) && tx_en && poll_pend;
  assign mem_req   = (st == ST_RREQ) || (st == ST_WB);
  assign mem_we    = (st == ST_WB);
  assign mem_addr  = (st == ST_WB) ? ptr : ptr + AW'({widx, 2'b00});
  assign mem_wdata = {{(WORD_W-2){1'b0}}, exc_q, late_q};
  assign cmd_valid = (st == ST_CMD);
  assign adv       = (st == ST_WB) && mem_ready;
  assign wrap      = end_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; widx <= '0; end_q <= 1'b0; late_q <= 1'b0; exc_q <= 1'b0;
      cmd_addr <= '0; cmd_len <= '0; cmd_first <= 1'b0; cmd_last <= 1'b0;
      tx_done <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      case (st)
        ST_IDLE: if (poll_take) begin st <= ST_RREQ; widx <= 2'd0; end
        ST_RREQ: if (mem_ready) st <= ST_RWAIT;
        ST_RWAIT: if (mem_rvalid) begin
          case (widx)
            2'd0: begin
              if (mem_rdata[OWN_BIT]) begin widx <= 2'd1; st <= ST_RREQ; end
              else st <= ST_IDLE;
            end
            2'd1: begin
              cmd_len   <= mem_rdata[LEN_W-1:0];
              cmd_first <= mem_rdata[FIRST_BIT];
              cmd_last  <= mem_rdata[LAST_BIT];
              end_q     <= mem_rdata[RINGEND_BIT];
              widx <= 2'd2; st <= ST_RREQ;
            end
            default: begin
              cmd_addr <= mem_rdata[AW-1:0];
              st <= ST_CMD;
            end
          endcase
        end
        ST_CMD: if (cmd_ready) st <= ST_BUSY;
        ST_BUSY: if (done_valid) begin
          late_q <= done_late; exc_q <= done_excess; st <= ST_WB;
        end
        ST_WB: if (mem_ready) begin
          tx_done <= 1'b1;
          widx    <= 2'd0;
          st      <= tx_en ? ST_RREQ : ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) &&
      $stable(cmd_len) && $stable(cmd_first) && $stable(cmd_last)));

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) &&
      $stable(mem_addr) && $stable(mem_wdata)));

  // R7
  done_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> $past(mem_req && mem_we && mem_ready));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !tx_en) |=> !mem_req);

  // R6
  wb_clears_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);
endmodule

// File: rtl/txr_walker.sv
module txr_walker #(
  parameter int AW       = 32,
  parameter int RAW      = 8,
  parameter int POLL_OFS = 24,
  parameter int BASE_OFS = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tx_en,
  input  logic                        reg_wr,
  input  logic [RAW-1:0]              reg_addr,
  input  logic [txr_pkg::WORD_W-1:0]  reg_wdata,
  output logic                        mem_req,
  output logic                        mem_we,
  output logic [AW-1:0]               mem_addr,
  output logic [txr_pkg::WORD_W-1:0]  mem_wdata,
  input  logic                        mem_ready,
  input  logic                        mem_rvalid,
  input  logic [txr_pkg::WORD_W-1:0]  mem_rdata,
  output logic                        cmd_valid,
  input  logic                        cmd_ready,
  output logic [AW-1:0]               cmd_addr,
  output logic [txr_pkg::LEN_W-1:0]   cmd_len,
  output logic                        cmd_first,
  output logic                        cmd_last,
  input  logic                        done_valid,
  input  logic                        done_late,
  input  logic                        done_excess,
  output logic                        tx_done
);
  logic          poll_pend, poll_take, base_load, adv, wrap;
  logic [AW-1:0] base_q, ptr;

  txr_regs #(.AW(AW), .RAW(RAW), .POLL_OFS(POLL_OFS), .BASE_OFS(BASE_OFS)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .poll_take(poll_take), .poll_pend(poll_pend),
    .base_q(base_q), .base_load(base_load));

  txr_ring_ptr #(.AW(AW)) ptr_i (
    .clk(clk), .rst_n(rst_n), .base_q(base_q), .base_load(base_load),
    .adv(adv), .wrap(wrap), .ptr(ptr));

  txr_engine #(.AW(AW)) eng_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .poll_pend(poll_pend),
    .poll_take(poll_take), .ptr(ptr), .adv(adv), .wrap(wrap),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_first(cmd_first),
    .cmd_last(cmd_last), .done_valid(done_valid), .done_late(done_late),
    .done_excess(done_excess), .tx_done(tx_done));
endmodule

// File: tb/txr_walker_tb.sv
`timescale 1ns/1ps
module txr_walker_tb_top;
  localparam logic [31:0] OWN  = 32'h8000_0000;
  localparam logic [31:0] REND = 32'h8000_0000;
  localparam logic [31:0] FST  = 32'h1000_0000;
  localparam logic [31:0] LST  = 32'h0800_0000;

  logic clk = 1'b0, rst_n = 1'b0, tx_en = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic mem_req, mem_we, mem_ready, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic cmd_valid, cmd_ready, cmd_first, cmd_last;
  logic [31:0] cmd_addr;
  logic [10:0] cmd_len;
  logic done_valid, done_late, done_excess, tx_done;

  always #2.5 clk = ~clk;

  txr_walker dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_first(cmd_first), .cmd_last(cmd_last),
    .done_valid(done_valid), .done_late(done_late),
    .done_excess(done_excess), .tx_done(tx_done));

  int errors = 0, checks = 0;
  bit finished = 0;

  // memory model
  logic [31:0] mem [0:255];
  logic stall_on = 1'b0, ready_hold = 1'b1;
  logic [1:0] stall_ctr = '0;
  int acc_cnt = 0, wr_cnt = 0;
  assign mem_ready = !stall_on || (stall_ctr == 2'b11);
  always @(posedge clk) begin
    stall_ctr  <= stall_ctr + 2'd1;
    mem_rvalid <= 1'b0;
    if (rst_n && mem_req && mem_ready) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) begin
        mem[mem_addr[9:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[9:2]];
      end
    end
  end

  // data path model
  logic [31:0] log_addr [0:31];
  logic [10:0] log_len  [0:31];
  logic        log_first [0:31], log_last [0:31];
  logic        fl_late [0:31], fl_exc [0:31];
  int cmd_cnt = 0, done_cnt = 0, overlap_err = 0, hold_err = 0, cur = 0;
  logic dp_busy = 1'b0, was_wait = 1'b0;
  logic [31:0] wait_addr;
  int dly = 0;
  assign cmd_ready = ready_hold;
  always @(posedge clk) begin
    done_valid <= 1'b0;
    if (tx_done) done_cnt <= done_cnt + 1;
    was_wait <= cmd_valid && !cmd_ready;
    wait_addr <= cmd_addr;
    if (was_wait && (!cmd_valid || cmd_addr != wait_addr)) hold_err <= hold_err + 1;
    if (cmd_valid && dp_busy) overlap_err <= overlap_err + 1;
    if (cmd_valid && cmd_ready) begin
      log_addr[cmd_cnt[4:0]]  <= cmd_addr;
      log_len[cmd_cnt[4:0]]   <= cmd_len;
      log_first[cmd_cnt[4:0]] <= cmd_first;
      log_last[cmd_cnt[4:0]]  <= cmd_last;
      cur <= cmd_cnt;
      cmd_cnt <= cmd_cnt + 1;
      dp_busy <= 1'b1;
      dly <= 4;
    end else if (dp_busy) begin
      if (dly == 0) begin
        done_valid  <= 1'b1;
        done_late   <= fl_late[cur[4:0]];
        done_excess <= fl_exc[cur[4:0]];
        dp_busy     <= 1'b0;
      end else dly <= dly - 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_desc(input int a, input logic [31:0] w0, w1, w2);
    mem[a>>2] = w0; mem[(a>>2)+1] = w1; mem[(a>>2)+2] = w2;
  endtask

  task automatic t_reset;
    check(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 0);
    check(cmd_valid == 1'b0, "R1 cmd_valid", 32'(cmd_valid), 0);
    check(tx_done == 1'b0, "R1 tx_done", 32'(tx_done), 0);
  endtask

  task automatic t_single;
    int c0 = cmd_cnt, d0 = done_cnt, w0 = wr_cnt;
    set_desc(32'h100, OWN, FST | LST | 32'd60, 32'h1234_5000);
    set_desc(32'h110, 32'h0, 32'h0, 32'h0);
    fl_late[c0[4:0]] = 1'b0; fl_exc[c0[4:0]] = 1'b0;
    reg_write(8'd32, 32'h100);
    reg_write(8'd24, 32'h0);
    wait_cyc(200);
    check(cmd_cnt == c0 + 1, "R2 one command", cmd_cnt - c0, 1);
    check(log_addr[c0[4:0]] == 32'h1234_5000, "R4 cmd_addr", log_addr[c0[4:0]], 32'h1234_5000);
    check(log_len[c0[4:0]] == 11'd60, "R4 cmd_len", 32'(log_len[c0[4:0]]), 60);
    check(log_first[c0[4:0]] && log_last[c0[4:0]], "R4 first/last",
          {log_first[c0[4:0]], log_last[c0[4:0]]}, 3);
    check(mem[32'h100>>2] == 32'h0, "R6 status word", mem[32'h100>>2], 0);
    check(done_cnt == d0 + 1, "R7 tx_done pulses", done_cnt - d0, 1);
    check(wr_cnt == w0 + 1, "R3 single write", wr_cnt - w0, 1);
  endtask

  task automatic t_wrap;
    int c0 = cmd_cnt, d0 = done_cnt;
    set_desc(32'h200, OWN, FST | 32'd100, 32'h0001_0000);
    set_desc(32'h210, OWN, REND | LST | 32'd200, 32'h0002_0000);
    fl_late[c0[4:0]] = 1'b1; fl_exc[c0[4:0]] = 1'b0;
    fl_late[(c0+1)%32] = 1'b0; fl_exc[(c0+1)%32] = 1'b1;
    fl_late[(c0+2)%32] = 1'b0; fl_exc[(c0+2)%32] = 1'b0;
    reg_write(8'd32, 32'h200);
    reg_write(8'd24, 32'h1);
    wait_cyc(250);
    check(cmd_cnt == c0 + 2, "R3 stops at software-owned", cmd_cnt - c0, 2);
    check(log_addr[(c0+1)%32] == 32'h0002_0000, "R4 second addr", log_addr[(c0+1)%32], 32'h0002_0000);
    check(log_first[c0[4:0]] && !log_last[c0[4:0]], "R4 first only",
          {log_first[c0[4:0]], log_last[c0[4:0]]}, 2);
    check(mem[32'h200>>2] == 32'h1, "R6 late bit", mem[32'h200>>2], 1);
    check(mem[32'h210>>2] == 32'h2, "R6 excess bit", mem[32'h210>>2], 2);
    check(done_cnt == d0 + 2, "R7 two pulses", done_cnt - d0, 2);
    mem[32'h200>>2] = OWN; mem[(32'h200>>2)+2] = 32'hAAAA_0000;
    reg_write(8'd24, 32'h0);
    wait_cyc(200);
    check(cmd_cnt == c0 + 3 && log_addr[(c0+2)%32] == 32'hAAAA_0000, "R8 wrap to base",
          log_addr[(c0+2)%32], 32'hAAAA_0000);
    check(mem[32'h200>>2] == 32'h0, "R6 clean status", mem[32'h200>>2], 0);
  endtask

  task automatic t_not_owned;
    int c0 = cmd_cnt, w0 = wr_cnt;
    reg_write(8'd24, 32'h0);
    wait_cyc(100);
    check(cmd_cnt == c0, "R3 no command", cmd_cnt - c0, 0);
    check(wr_cnt == w0, "R3 no write", wr_cnt - w0, 0);
    check(mem[32'h210>>2] == 32'h2, "R3 word untouched", mem[32'h210>>2], 2);
  endtask

  task automatic t_disabled_poll;
    int c0 = cmd_cnt, a0;
    set_desc(32'h300, OWN, FST | LST | 32'd64, 32'h0003_0000);
    set_desc(32'h310, 32'h0, 32'h0, 32'h0);
    fl_late[c0[4:0]] = 1'b0; fl_exc[c0[4:0]] = 1'b0;
    tx_en = 1'b0;
    reg_write(8'd32, 32'h300);
    a0 = acc_cnt;
    reg_write(8'd24, 32'h0);
    wait_cyc(100);
    check(acc_cnt == a0, "R10 no access while disabled", acc_cnt - a0, 0);
    check(cmd_cnt == c0, "R2 held while disabled", cmd_cnt - c0, 0);
    tx_en = 1'b1;
    wait_cyc(150);
    check(cmd_cnt == c0 + 1, "R2 pending poll honoured", cmd_cnt - c0, 1);
  endtask

  task automatic t_stop_midway;
    int c0 = cmd_cnt, d0 = done_cnt, n = 0;
    set_desc(32'h340, OWN, FST | LST | 32'd70, 32'h0004_0000);
    set_desc(32'h350, OWN, FST | LST | 32'd80, 32'h0005_0000);
    set_desc(32'h360, 32'h0, 32'h0, 32'h0);
    fl_late[c0[4:0]] = 1'b0; fl_exc[c0[4:0]] = 1'b0;
    fl_late[(c0+1)%32] = 1'b0; fl_exc[(c0+1)%32] = 1'b0;
    reg_write(8'd32, 32'h340);
    reg_write(8'd24, 32'h0);
    while (cmd_cnt == c0 && n < 200) begin wait_cyc(1); n++; end
    tx_en = 1'b0;
    wait_cyc(150);
    check(cmd_cnt == c0 + 1, "R10 stops after current", cmd_cnt - c0, 1);
    check(mem[32'h340>>2] == 32'h0, "R10 current completes", mem[32'h340>>2], 0);
    check(mem[32'h350>>2] == OWN, "R10 next untouched", mem[32'h350>>2], OWN);
    check(done_cnt == d0 + 1, "R7 one pulse", done_cnt - d0, 1);
    tx_en = 1'b1;
    reg_write(8'd24, 32'h0);
    wait_cyc(150);
    check(cmd_cnt == c0 + 2 && log_addr[(c0+1)%32] == 32'h0005_0000,
          "R8 position kept", log_addr[(c0+1)%32], 32'h0005_0000);
  endtask

  task automatic t_backpressure;
    int c0 = cmd_cnt;
    set_desc(32'h380, OWN, FST | LST | 32'd1500, 32'hDEAD_BEE0);
    set_desc(32'h390, 32'h0, 32'h0, 32'h0);
    fl_late[c0[4:0]] = 1'b1; fl_exc[c0[4:0]] = 1'b1;
    stall_on = 1'b1; ready_hold = 1'b0;
    reg_write(8'd32, 32'h380);
    reg_write(8'd24, 32'h0);
    wait_cyc(120);
    check(cmd_valid == 1'b1 && cmd_addr == 32'hDEAD_BEE0, "R5 held command", cmd_addr, 32'hDEAD_BEE0);
    ready_hold = 1'b1;
    wait_cyc(200);
    check(cmd_cnt == c0 + 1 && log_len[c0[4:0]] == 11'd1500, "R11 len under stall",
          32'(log_len[c0[4:0]]), 1500);
    check(mem[32'h380>>2] == 32'h3, "R11 writeback under stall", mem[32'h380>>2], 3);
    stall_on = 1'b0;
  endtask

  task automatic t_base_reload;
    int c0 = cmd_cnt;
    set_desc(32'h380, OWN, FST | LST | 32'd90, 32'h0006_0000);
    mem[32'h390>>2] = OWN; mem[(32'h390>>2)+1] = FST | LST | 32'd91;
    mem[(32'h390>>2)+2] = 32'h0007_0000;
    mem[32'h3A0>>2] = 32'h0;
    fl_late[c0[4:0]] = 1'b0; fl_exc[c0[4:0]] = 1'b0;
    fl_late[(c0+1)%32] = 1'b0; fl_exc[(c0+1)%32] = 1'b0;
    reg_write(8'd32, 32'h38F);
    reg_write(8'd24, 32'h0);
    wait_cyc(250);
    check(cmd_cnt >= c0 + 1 && log_addr[c0[4:0]] == 32'h0006_0000, "R9 reload resets position",
          log_addr[c0[4:0]], 32'h0006_0000);
    check(overlap_err == 0, "R6 one frame in flight", overlap_err, 0);
    check(hold_err == 0, "R5 hold monitor", hold_err, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    for (int i = 0; i < 32; i++) begin fl_late[i] = 1'b0; fl_exc[i] = 1'b0; end
    done_late = 1'b0; done_excess = 1'b0;
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    tx_en = 1'b1;
    wait_cyc(2);
    t_single;
    t_wrap;
    t_not_owned;
    t_disabled_poll;
    t_stop_midway;
    t_backpressure;
    t_base_reload;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule